// File: doc/BRIEF.md
# PPS Clock-Gap SYNC Sequencer

This block sits in the FPGA that produces a high-speed source clock. It marks the start of every second by briefly stopping the clocks that an external channel-divider stage hands out. It does this through the divider's active-low synchronization line. While that line is low, the divided outputs sit at logic 0. The divider restarts them a fixed pipeline delay after the line rises. Because of this, releasing the line a fixed number of source cycles ahead of the second boundary lines the first restored edge up with that boundary. A receiver that counts the distributed clock can then clear its count whenever it sees the clock go missing.

A free-running counter runs over one second's worth of source cycles, `cycles_per_sec`. The line is pulled low for `gap_len` cycles and released 14 cycles before the count returns to zero. A one-cycle strobe marks count zero so that the alignment can be observed. The period and the gap are sampled only at a second boundary. The gap is forced into a legal range whose ceiling keeps the low time well under 1 us. After reset, or after `enable` drops, no gap is issued until `enable` has been held high across a whole second.

Top module: `pps_gap_sequencer`

## Requirements
- R1: `pps_strobe` is high for exactly one cycle at count 0 of every second, and consecutive strobes are N cycles apart, where N is the sampled `cycles_per_sec`; a value below 2 is treated as 2.
- R2: When armed, `sync_n` goes low at count N-14-G and stays low for exactly G consecutive cycles in that second, where G is the sampled gap after range limiting.
- R3: The rising edge of `sync_n` at the end of a gap occurs exactly 14 cycles before the next `pps_strobe`.
- R4: A `gap_len` below 2 is raised to 2 cycles.
- R5: A `gap_len` above the ceiling of SRC_CLK_MHZ/2 cycles (250 at the default 500) is lowered to the ceiling, so no low run is longer than that ceiling.
- R6: If N is not larger than 14+G, no gap is issued in that second, and `sync_n` stays high.
- R7: `cycles_per_sec` and `gap_len` are captured during reset and at each second boundary. A change made during a second takes effect from the next second on.
- R8: During reset `sync_n` is high and `pps_strobe` is low. With `enable` high from reset, the seconds that begin at the first strobe and before it carry no gap, and the first gap falls in the second that begins at the second strobe.
- R9: While `enable` is low, `sync_n` is high from the following cycle on and the block disarms. After `enable` returns, the rest of that second and the whole next second carry no gap, and gaps resume in the second after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed source clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows gap generation once held for a full second |
| cycles_per_sec | input | 32 | Source cycles per second (N) |
| gap_len | input | 10 | Requested low time of the SYNC line in source cycles |
| sync_n | output | 1 | Active-low divider synchronization line |
| pps_strobe | output | 1 | One-cycle strobe at count 0 |

## Verification
A wrong count or a stale period capture shows at the ports within one second, as a strobe spacing that differs from N and as a gap whose start offset from the previous strobe is not N-14-G. An off-by-one in the release compare moves the rising edge of `sync_n` so it is no longer 14 cycles before the next strobe, which is seen at the very next boundary. A wrong arming state shows as a gap in a second that should be clean, or as a missing one. This appears within the two seconds that follow reset or the drop of `enable`.

// File: rtl/pps_seq_pkg.sv
package pps_seq_pkg;

    localparam int CNT_W = 32;
    localparam int GAP_W = 10;
    localparam int MIN_PERIOD = 2;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [GAP_W-1:0] gap;
        logic             fits;
    } seq_cfg_t;

    function automatic logic [CNT_W-1:0] limit_period(input logic [CNT_W-1:0] raw);
        return (raw < CNT_W'(MIN_PERIOD)) ? CNT_W'(MIN_PERIOD) : raw;
    endfunction

    function automatic logic [GAP_W-1:0] limit_gap(input logic [GAP_W-1:0] raw,
                                                   input logic [GAP_W-1:0] lo,
                                                   input logic [GAP_W-1:0] hi);
        logic [GAP_W-1:0] v;
        v = raw;
        if (v < lo) v = lo;
        if (v > hi) v = hi;
        return v;
    endfunction

    function automatic logic window_fits(input logic [CNT_W-1:0] period,
                                         input logic [GAP_W-1:0] gap,
                                         input logic [CNT_W-1:0] lead);
        return period > (lead + CNT_W'(gap));
    endfunction

endpackage

// File: rtl/pps_sec_counter.sv
module pps_sec_counter
    import pps_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  seq_cfg_t         cfg_in,
    output seq_cfg_t         cfg_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt;

    always_comb begin
        wrap    = (cnt == (cfg_q.period - CNT_W'(1)));
        cnt_nxt = wrap ? '0 : cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            cfg_q <= cfg_in;
        end else begin
            cnt <= cnt_nxt;
            if (wrap) cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/pps_arm_ctrl.sv
module pps_arm_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic wrap,
    output logic armed_nxt
);
    logic armed_q;
    logic en_run;

    always_comb armed_nxt = enable && (armed_q || (wrap && en_run));

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            en_run  <= 1'b0;
        end else begin
            armed_q <= armed_nxt;
            en_run  <= wrap ? enable : (en_run && enable);
        end
    end
endmodule

// File: rtl/pps_gap_window.sv
module pps_gap_window
    import pps_seq_pkg::*;
#(
    parameter int LEAD_CYC = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_cfg_t         cfg_q,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic             armed_nxt,
    output logic             sync_n,
    output logic             pps_strobe
);
    localparam logic [CNT_W-1:0] LEAD = CNT_W'(LEAD_CYC);

    logic [CNT_W-1:0] win_open;
    logic [CNT_W-1:0] win_close;
    logic             in_win;

    always_comb begin
        win_close = cfg_q.period - LEAD;
        win_open  = win_close - CNT_W'(cfg_q.gap);
        in_win    = cfg_q.fits && (cnt_nxt >= win_open) && (cnt_nxt < win_close);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_n     <= 1'b1;
            pps_strobe <= 1'b0;
        end else begin
            sync_n     <= !(armed_nxt && in_win);
            pps_strobe <= (cnt_nxt == '0);
        end
    end
endmodule

// File: rtl/pps_gap_sequencer.sv
module pps_gap_sequencer
    import pps_seq_pkg::*;
#(
    parameter int LEAD_CYC    = 14,
    parameter int GAP_MIN     = 2,
    parameter int SRC_CLK_MHZ = 500
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [CNT_W-1:0] cycles_per_sec,
    input  logic [GAP_W-1:0] gap_len,
    output logic             sync_n,
    output logic             pps_strobe
);
    localparam int GAP_CEIL = SRC_CLK_MHZ / 2;
    localparam logic [GAP_W-1:0] GAP_LO = GAP_W'(GAP_MIN);
    localparam logic [GAP_W-1:0] GAP_HI = GAP_W'(GAP_CEIL);

    seq_cfg_t         cfg_in;
    seq_cfg_t         cfg_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             wrap;
    logic             armed_nxt;

    always_comb begin
        cfg_in.period = limit_period(cycles_per_sec);
        cfg_in.gap    = limit_gap(gap_len, GAP_LO, GAP_HI);
        cfg_in.fits   = window_fits(cfg_in.period, cfg_in.gap, CNT_W'(LEAD_CYC));
    end

    pps_sec_counter i_counter (
        .clk     (clk),
        .rst     (rst),
        .cfg_in  (cfg_in),
        .cfg_q   (cfg_q),
        .cnt_nxt (cnt_nxt),
        .wrap    (wrap)
    );

    pps_arm_ctrl i_arm (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .wrap      (wrap),
        .armed_nxt (armed_nxt)
    );

    pps_gap_window #(.LEAD_CYC(LEAD_CYC)) i_window (
        .clk        (clk),
        .rst        (rst),
        .cfg_q      (cfg_q),
        .cnt_nxt    (cnt_nxt),
        .armed_nxt  (armed_nxt),
        .sync_n     (sync_n),
        .pps_strobe (pps_strobe)
    );
endmodule

// File: rtl/pps_gap_sequencer_chk.sv
module pps_gap_sequencer_chk #(
    parameter int LEAD_CYC    = 14,
    parameter int GAP_MIN     = 2,
    parameter int SRC_CLK_MHZ = 500
) (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic sync_n,
    input logic pps_strobe
);
    localparam int GAP_CEIL = SRC_CLK_MHZ / 2;

    logic     prev_sync;
    logic     prev_en;
    logic     pend;
    int       since_rise;
    int       low_run;
    logic     gap_end;

    always_comb gap_end = sync_n && !prev_sync && prev_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sync  <= 1'b1;
            prev_en    <= 1'b0;
            pend       <= 1'b0;
            since_rise <= 0;
            low_run    <= 0;
        end else begin
            prev_sync <= sync_n;
            prev_en   <= enable;
            low_run   <= sync_n ? 0 : low_run + 1;
            if (gap_end) begin
                pend       <= 1'b1;
                since_rise <= 1;
            end else if (pps_strobe) begin
                pend <= 1'b0;
            end else if (pend) begin
                since_rise <= since_rise + 1;
            end
        end
    end

    assert_pps_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
        pps_strobe |=> !pps_strobe);

    assert_release_lead_R3: assert property (@(posedge clk) disable iff (rst)
        (pps_strobe && pend) |-> (since_rise == LEAD_CYC));

    assert_gap_floor_R4: assert property (@(posedge clk) disable iff (rst)
        gap_end |-> (low_run >= GAP_MIN));

    assert_gap_ceiling_R5: assert property (@(posedge clk) disable iff (rst)
        low_run <= GAP_CEIL);

    assert_disable_releases_R9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> sync_n);
endmodule

bind pps_gap_sequencer pps_gap_sequencer_chk #(
    .LEAD_CYC    (LEAD_CYC),
    .GAP_MIN     (GAP_MIN),
    .SRC_CLK_MHZ (SRC_CLK_MHZ)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .sync_n     (sync_n),
    .pps_strobe (pps_strobe)
);

// File: tb/test_pps_gap_sequencer.sv
module test_pps_gap_sequencer;
    import pps_seq_pkg::*;

    localparam int LEAD = 14;

    typedef struct {
        int    period;
        int    gap;
        string req;
    } sec_item_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enable = 1'b1;
    logic [CNT_W-1:0] cycles_per_sec = 64;
    logic [GAP_W-1:0] gap_len = 5;
    logic             sync_n;
    logic             pps_strobe;

    int checks = 0;
    int errors = 0;
    sec_item_t sb_q[$];

    always #10 clk = ~clk;

    pps_gap_sequencer i_pps_gap_sequencer (
        .clk            (clk),
        .rst            (rst),
        .enable         (enable),
        .cycles_per_sec (cycles_per_sec),
        .gap_len        (gap_len),
        .sync_n         (sync_n),
        .pps_strobe     (pps_strobe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_second(input int p, input int g, input string req);
        sec_item_t it;
        it.period = p;
        it.gap    = g;
        it.req    = req;
        sb_q.push_back(it);
    endtask

    task automatic wait_pps();
        do @(negedge clk); while (!pps_strobe);
    endtask

    // monitor
    int  off = 0, low_tot = 0, runs = 0, fall_off = -1, rise_off = -1;
    bit  prev_sync = 1'b1, prev_pps = 1'b0, started = 1'b0, rst_seen = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            if (!rst_seen) begin
                check(sync_n === 1'b1, "R8 sync_n in reset", int'(sync_n), 1);
                check(pps_strobe === 1'b0, "R8 pps_strobe in reset", int'(pps_strobe), 0);
                rst_seen = 1'b1;
            end
        end else begin
            if (pps_strobe) begin
                check(!prev_pps, "R1 strobe width", 2, 1);
                if (!started) begin
                    check(low_tot == 0, "R8 no gap before first strobe", low_tot, 0);
                    started = 1'b1;
                end else if (sb_q.size() == 0) begin
                    check(1'b0, "scoreboard underflow", 0, 1);
                end else begin
                    sec_item_t it;
                    it = sb_q.pop_front();
                    check(off == it.period, {"R1 period ", it.req}, off, it.period);
                    if (it.gap > 0) begin
                        check(runs == 1 && low_tot == it.gap, {"R2 gap length ", it.req}, low_tot, it.gap);
                        check(fall_off == it.period - LEAD - it.gap, {"R2 gap start ", it.req},
                              fall_off, it.period - LEAD - it.gap);
                        check(off - rise_off == LEAD, {"R3 release lead ", it.req}, off - rise_off, LEAD);
                    end else begin
                        check(low_tot == 0, {"no gap ", it.req}, low_tot, 0);
                    end
                end
                off = 0; low_tot = 0; runs = 0; fall_off = -1; rise_off = -1;
            end
            if (!sync_n) begin
                low_tot++;
                if (prev_sync) begin
                    runs++;
                    fall_off = off;
                end
            end else if (!prev_sync) begin
                rise_off = off;
            end
            prev_sync = sync_n;
            prev_pps  = pps_strobe;
            off++;
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // driver
    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        expect_second(64, 0, "R8 arming second");
        expect_second(64, 5, "R2 first armed second");
        expect_second(64, 5, "R2 steady");
        wait_pps(); wait_pps(); wait_pps();
        gap_len = 1;                       // R4 raised to 2, R7 takes effect next second
        expect_second(64, 2, "R4 R7 gap floor");
        wait_pps();
        cycles_per_sec = 400; gap_len = 300;
        expect_second(400, 250, "R5 gap ceiling");
        wait_pps();
        cycles_per_sec = 20; gap_len = 10;
        expect_second(20, 0, "R6 window does not fit");
        wait_pps();
        cycles_per_sec = 64; gap_len = 7;
        expect_second(64, 7, "R7 new config");
        wait_pps();
        wait_pps();
        repeat (10) @(negedge clk);
        enable = 1'b0;
        repeat (3) @(negedge clk);
        check(sync_n === 1'b1, "R9 sync_n high while disabled", int'(sync_n), 1);
        enable = 1'b1;
        expect_second(64, 0, "R9 disabled second");
        expect_second(64, 0, "R9 rearm second");
        expect_second(64, 7, "R9 rearmed");
        wait_pps(); wait_pps(); wait_pps();
        repeat (2) @(negedge clk);
        check(sb_q.size() == 0, "R1 all seconds observed", sb_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule